// File: doc/BRIEF.md
# Clear/Preset Flip-Flop Register

This block is a row of rising-edge D flip-flops. Each bit is built from two level-sensitive latches working on opposite clock phases. Every latch can be forced to a known value through an initialization path. That path is gated by an enable, not by separate set and reset pins.

In the default variant, each bit makes its own enable as the exclusive-OR of its clear and preset requests:

- Clear alone drives the bit low at once.
- Preset alone drives the bit high at once.
- Clear and preset together give a low enable, so the flip-flop keeps clocking normally. A simultaneous set and reset cannot happen.

In the external-enable variant, one shared enable replaces the exclusive-OR. This suits a counter reload pulse that loads a control word into the register, or the AND of a phase detector's outputs.

When the initialization ends, the bit leaves the forced state on the next rising edge of the clock and loads D. No extra transition happens before that edge. A synchronous active-low reset loads zero on a rising edge. Any initialization that is active overrides it.

Top module: `preset_clear_dff`

## Requirements
- R1: While no initialization is active, q takes the value of d present at each rising clk edge and does not change at any other time.
- R2: qn is always the bitwise inverse of q.
- R3: With clr high and pre low on a bit whose initialization is enabled, that bit's q goes to 0 without waiting for a clock edge, whatever d and clk are.
- R4: With pre high and clr low on a bit whose initialization is enabled, that bit's q goes to 1 without waiting for a clock edge, whatever d and clk are.
- R5: With EXT_EN=0, a bit with clr and pre both high behaves exactly as in R1.
- R6: While a forcing initialization stays active across rising clk edges, q keeps the forced value and ignores d.
- R7: After a forcing initialization ends, q keeps the forced value until the next rising clk edge. That edge loads d.
- R8: With EXT_EN=1 and ext_en low, clr and pre have no effect on q.
- R9: With EXT_EN=1, ext_en high, and clr equal to pre on a bit, that bit holds its value across rising clk edges.
- R10: With EXT_EN=0, ext_en has no effect on q.
- R11: With rst_n low at a rising clk edge, every bit without an active initialization loads 0. A forcing initialization overrides the reset.
- R12: With qn[0] fed back to d[0], bit 0 toggles on every rising edge. A preset pulse pulls it high and a clear pulse pulls it low, and toggling resumes from the forced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register loads on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| d | input | WIDTH | Data to load |
| clr | input | WIDTH | Clear request per bit |
| pre | input | WIDTH | Preset request per bit |
| ext_en | input | 1 | Shared initialization enable, used only when EXT_EN=1 |
| q | output | WIDTH | Register output |
| qn | output | WIDTH | Inverted register output |

## Verification
The bench builds two copies of the block:

- A 4-bit copy with the internal exclusive-OR enable. Its bit 0 can be wired as a divide-by-two, which exercises the toggle-and-force sequence.
- A 3-bit copy with the shared external enable. This brings the hold-on-equal-requests case and the ignored-requests case within reach, neither of which the internal variant can produce.

Inputs change only on falling edges. The bench checks the register just after each falling edge, where asynchronous forcing is visible, and again just after each rising edge, where loads take effect.

// File: rtl/sr_init_pkg.sv
// Package: shared types for the clear/preset flip-flop register.
// Assumes: nothing; holds only type and function declarations.
package sr_init_pkg;

    // Action the initialization stage applies while its enable is high.
    typedef enum logic [1:0] {
        INIT_HOLD  = 2'd0,
        INIT_CLEAR = 2'd1,
        INIT_SET   = 2'd2
    } init_cmd_e;

    // Turns one clear/preset request pair into an initialization action.
    function automatic init_cmd_e decode_cmd(input logic c, input logic p);
        if (c && !p)
            return INIT_CLEAR;
        else if (p && !c)
            return INIT_SET;
        else
            return INIT_HOLD;
    endfunction

endpackage

// File: rtl/init_steer.sv
// Module: init_steer
// Produces one initialization enable and one action per bit.
// EXT_EN=0: each bit's enable is clr^pre, so an enabled bit always receives
//           a clear or a set action.
// EXT_EN=1: the shared ext_en drives every bit's enable; a bit with equal
//           requests then receives the hold action.
// Assumes: inputs are level signals; the logic is purely combinational.
module init_steer
    import sr_init_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit EXT_EN = 1'b0
) (
    input  logic [WIDTH-1:0] clr,
    input  logic [WIDTH-1:0] pre,
    input  logic             ext_en,
    output logic [WIDTH-1:0] en,
    output init_cmd_e        cmd [WIDTH]
);

    // Per-bit action decode, shared by both variants.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cmd
        assign cmd[i] = decode_cmd(clr[i], pre[i]);
    end

    // Variant select: internal exclusive-OR or external shared enable.
    if (EXT_EN) begin : g_ext
        assign en = {WIDTH{ext_en}};
    end else begin : g_xor
        logic ext_en_unused;
        assign ext_en_unused = ext_en;
        assign en = clr ^ pre;
    end

endmodule

// File: rtl/gated_latch.sv
// Module: gated_latch
// A level-sensitive D latch with an initialization override.
// While en is high, the latch follows cmd: it sets, clears or freezes.
// While en is low, the latch is transparent during the clk level chosen by
// TRANSPARENT_HIGH and holds otherwise.
// Assumes: clk is read directly, not through an inverter, so that both
//          latches of a pair see the same edge in the same instant.
module gated_latch
    import sr_init_pkg::*;
#(
    parameter bit TRANSPARENT_HIGH = 1'b1
) (
    input  logic      clk,
    input  logic      d,
    input  logic      en,
    input  init_cmd_e cmd,
    output logic      q
);

    // Storage: initialization has priority over normal transparency.
    always_latch begin
        if (en) begin
            if (cmd == INIT_SET)
                q <= 1'b1;
            else if (cmd == INIT_CLEAR)
                q <= 1'b0;
        end else if (clk == TRANSPARENT_HIGH) begin
            q <= d;
        end
    end

endmodule

// File: rtl/ms_bit.sv
// Module: ms_bit
// One master-slave flip-flop bit. The master is open while clk is low and
// the slave is open while clk is high, so the bit loads on the rising edge.
// Both latches receive the same initialization, so a forced value reaches q
// at once and the next rising edge loads d again.
// Assumes: rst_n is synchronous; it gates the master's data input only.
module ms_bit
    import sr_init_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      d,
    input  logic      en,
    input  init_cmd_e cmd,
    output logic      q,
    output logic      qn
);

    logic m_d;
    logic m_q;

    // Reset steering: a low rst_n presents 0 to the master.
    assign m_d = rst_n ? d : 1'b0;

    gated_latch #(.TRANSPARENT_HIGH(1'b0)) u_master (
        .clk (clk),
        .d   (m_d),
        .en  (en),
        .cmd (cmd),
        .q   (m_q)
    );

    gated_latch #(.TRANSPARENT_HIGH(1'b1)) u_slave (
        .clk (clk),
        .d   (m_q),
        .en  (en),
        .cmd (cmd),
        .q   (q)
    );

    // Inverted output.
    assign qn = ~q;

    // R1: with no initialization over a whole period, the edge loads d (0 under reset).
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> (q == ($past(rst_n) ? $past(d) : 1'b0)));

    // R3: a clear action holds q low.
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == INIT_CLEAR) |-> !q);

    // R4: a set action holds q high.
    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cmd == INIT_SET) |-> q);

    // R7: q still shows the forced value at the first edge after release.
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !en && $past(cmd) != INIT_HOLD)
            |-> (q == ($past(cmd) == INIT_SET)));

    // R9: a hold action kept across an edge freezes q.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(cmd) == INIT_HOLD && en && cmd == INIT_HOLD)
            |-> $stable(q));

endmodule

// File: rtl/preset_clear_dff.sv
// Module: preset_clear_dff (top)
// A WIDTH-bit register of master-slave flip-flops with clear/preset
// initialization gated by an enable. EXT_EN selects the enable source:
// each bit's own clr^pre, or the shared ext_en.
// Assumes: clr, pre and ext_en may change at any time; d is sampled on the
//          rising clk edge.
module preset_clear_dff
    import sr_init_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit EXT_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] clr,
    input  logic [WIDTH-1:0] pre,
    input  logic             ext_en,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] qn
);

    logic [WIDTH-1:0] en;
    init_cmd_e        cmd [WIDTH];

    init_steer #(.WIDTH(WIDTH), .EXT_EN(EXT_EN)) u_steer (
        .clr    (clr),
        .pre    (pre),
        .ext_en (ext_en),
        .en     (en),
        .cmd    (cmd)
    );

    // One flip-flop per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        ms_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (d[i]),
            .en    (en[i]),
            .cmd   (cmd[i]),
            .q     (q[i]),
            .qn    (qn[i])
        );
    end

endmodule

// File: tb/test_preset_clear_dff.sv
module test_preset_clear_dff;

    localparam int W  = 4;
    localparam int WX = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [W-1:0]  d_r = '0, clr = '0, pre = '0;
    logic          ext_en = 1'b0;
    logic          div_mode = 1'b0;
    logic [W-1:0]  q_a, qn_a;
    logic [WX-1:0] q_b, qn_b;
    logic [W-1:0]  d_a;

    assign d_a = div_mode ? {d_r[W-1:1], qn_a[0]} : d_r;

    preset_clear_dff #(.WIDTH(W), .EXT_EN(1'b0)) i_preset_clear_dff (
        .clk(clk), .rst_n(rst_n), .d(d_a), .clr(clr), .pre(pre),
        .ext_en(ext_en), .q(q_a), .qn(qn_a));

    preset_clear_dff #(.WIDTH(WX), .EXT_EN(1'b1)) i_preset_clear_dff_ext (
        .clk(clk), .rst_n(rst_n), .d(d_r[WX-1:0]), .clr(clr[WX-1:0]),
        .pre(pre[WX-1:0]), .ext_en(ext_en), .q(q_b), .qn(qn_b));

    int checks = 0;
    int errors = 0;
    logic [W-1:0]  exp_a = '0;
    logic [WX-1:0] exp_b = '0;
    logic [W-1:0]  was_forced = '0;
    logic          valid = 1'b0;

    task automatic check_bit(input string tag, input int idx, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s bit %0d at %0t: actual %b expected %b", tag, idx, $time, act, expv);
        end
    endtask

    // Checks taken just after a falling edge, where forcing is visible.
    task automatic check_neg(input logic [W-1:0] cv, pv, input logic ev);
        for (int i = 0; i < W; i++) begin
            string t;
            if (cv[i] ^ pv[i]) t = pv[i] ? "R4" : "R3";
            else if (was_forced[i]) t = "R7";
            else if (ev) t = "R10";
            else t = "R1";
            check_bit(t, i, q_a[i], exp_a[i]);
            check_bit("R2", i, qn_a[i], ~exp_a[i]);
        end
        for (int i = 0; i < WX; i++) begin
            string t;
            if (ev && cv[i] != pv[i]) t = pv[i] ? "R4" : "R3";
            else if (ev) t = "R9";
            else if (cv[i] != pv[i]) t = "R8";
            else t = "R1";
            check_bit(t, i, q_b[i], exp_b[i]);
            check_bit("R2", i, qn_b[i], ~exp_b[i]);
        end
    endtask

    // Checks taken just after a rising edge, where loads take effect.
    task automatic check_pos(input logic [W-1:0] cv, pv, input logic ev, rv, dm);
        for (int i = 0; i < W; i++) begin
            string t;
            if (cv[i] ^ pv[i]) t = "R6";
            else if (cv[i] & pv[i]) t = "R5";
            else if (!rv) t = "R11";
            else if (dm && i == 0) t = "R12";
            else t = "R1";
            check_bit(t, i, q_a[i], exp_a[i]);
        end
        for (int i = 0; i < WX; i++) begin
            string t;
            if (ev) t = (cv[i] != pv[i]) ? "R6" : "R9";
            else if (cv[i] != pv[i]) t = "R8";
            else if (!rv) t = "R11";
            else t = "R1";
            check_bit(t, i, q_b[i], exp_b[i]);
        end
    endtask

    // One clock period: drive on the falling edge, model and check both phases.
    task automatic step(input logic [W-1:0] dv, cv, pv, input logic ev, rv, dm);
        logic [W-1:0] nxt;
        @(negedge clk);
        d_r = dv; clr = cv; pre = pv; ext_en = ev; rst_n = rv; div_mode = dm;
        #1;
        for (int i = 0; i < W; i++)
            if (cv[i] ^ pv[i]) exp_a[i] = pv[i];
        for (int i = 0; i < WX; i++)
            if (ev && cv[i] != pv[i]) exp_b[i] = pv[i];
        if (valid) check_neg(cv, pv, ev);
        @(posedge clk);
        nxt = exp_a;
        for (int i = 0; i < W; i++)
            if (!(cv[i] ^ pv[i]))
                nxt[i] = !rv ? 1'b0 : ((dm && i == 0) ? ~exp_a[0] : dv[i]);
        exp_a = nxt;
        for (int i = 0; i < WX; i++)
            if (!ev) exp_b[i] = rv ? dv[i] : 1'b0;
        was_forced = cv ^ pv;
        #1;
        check_pos(cv, pv, ev, rv, dm);
        valid = 1'b1;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd13579));
        // R11: reset loads zero.
        step(4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0);
        step(4'b1011, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0);
        // R1: plain loads with several patterns.
        step(4'b0101, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0);
        step(4'b1010, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0);
        step(4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0);
        // R3 and R6: clear held across edges while d is all ones.
        step(4'b1111, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0);
        step(4'b1111, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0);
        // R7: release, then the next edge loads d.
        step(4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0);
        // R4: preset against d of zero, then release.
        step(4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b0);
        step(4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0);
        // R5: both requests high, normal loads continue.
        step(4'b0110, 4'b1111, 4'b1111, 1'b0, 1'b1, 1'b0);
        step(4'b1001, 4'b1111, 4'b1111, 1'b0, 1'b1, 1'b0);
        // R10 and R9: ext_en high with no requests.
        step(4'b0110, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0);
        step(4'b0011, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0);
        // R8: requests with ext_en low leave the external variant loading.
        step(4'b0000, 4'b0111, 4'b0000, 1'b0, 1'b1, 1'b0);
        step(4'b0101, 4'b0000, 4'b0111, 1'b0, 1'b1, 1'b0);
        // R11: forcing overrides reset.
        step(4'b1111, 4'b0000, 4'b0011, 1'b1, 1'b0, 1'b0);
        step(4'b1111, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0);
        // R12: divide-by-two with preset and clear pulses.
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 4; j++)
                step(4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1);
            step(4'b0000, 4'b0000, 4'b0001, 1'b0, 1'b1, 1'b1);
            step(4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1);
            step(4'b0000, 4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1);
            step(4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1);
        end
        // Random mix of loads, requests, enable and reset.
        for (int n = 0; n < 600; n++) begin
            logic [W-1:0] dv, cv, pv;
            logic ev, rv, dm;
            dv = W'($urandom);
            cv = W'($urandom) & W'($urandom);
            pv = W'($urandom) & W'($urandom);
            ev = ($urandom % 3) == 0;
            rv = ($urandom % 12) != 0;
            dm = (n >= 300);
            step(dv, cv, pv, ev, rv, dm);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule